// File: doc/BRIEF.md
# ChaCha Keystream Block Engine

This block turns a 512-bit ChaCha state (sixteen 32-bit words laid out as four rows of four) into keystream and XORs it onto a data block. A state, a data group, a round count, a mode bit and a byte length are accepted together through a valid/ready handshake. The engine then iterates the ChaCha permutation: one full round (all four quarter-rounds of a pass) per clock, alternating column passes with diagonal passes. The diagonal pass is formed by rotating rows 1, 2 and 3 by one, two and three word positions, running the column quarter-rounds and rotating back. After the last round the original state is added back word by word. The sum is XORed with the data and presented on a valid/ready output.

In single mode one 64-byte block is produced. In group mode four lanes run side by side from the same state, lane k using word 12 plus k as its block counter. The output carries the four blocks in counter order, 256 bytes in all. A byte length masks the tail of the group: bytes at or past the length are neither XORed nor flagged as kept. A round count that is odd or zero is refused, and the output then returns an error flag with no data. Words are serialised little-endian, so output byte b sits at bits [8b+7:8b] of the output vector. The engine takes no new input until its output handshake has completed.

Top module: `kse_block_engine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: For an even nonzero round count N, output word i of block 0 equals data word i XOR (state word i after N rounds + original state word i). The rounds are column and diagonal passes in alternation, beginning with a column pass. Each quarter-round uses add/xor/rotate-left steps by 16, 12, 8 and 7 bits, and every addition is modulo 2^32.
- R3: With 20 rounds, all-zero data and the standard test state (constants, key bytes 0x00..0x1f, counter 1, nonce words 0x09000000, 0x4a000000, 0), output word 0 is 0xe4e7f110.
- R4: For a valid round count N, out_valid rises exactly N clock cycles after the accepting edge, at the (N)th following rising edge.
- R5: An odd or zero round count sets out_err, with out_keep all zero and out_data all zero, on the edge that accepts the request.
- R6: In group mode (in_multi=1), block k (bits [512k+511:512k]) is computed with counter word 12 replaced by word 12 + k modulo 2^32, for k = 0..3.
- R7: out_keep bit b is 1 exactly when b < in_len (and, in single mode, also b < 64). Byte b of out_data (bits [8b+7:8b]) is zero where out_keep bit b is 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_keep hold. in_ready stays 0 from acceptance until the output handshake, and a request offered then is ignored.
- R9: In single mode, out_keep bits 64..255 and out_data bits 512..2047 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Engine idle and able to accept |
| in_state | input | 512 | ChaCha state, word i at bits [32i+31:32i] |
| in_data | input | 2048 | Data group, byte b at bits [8b+7:8b] |
| in_rounds | input | 5 | Round count, even and nonzero |
| in_multi | input | 1 | 1: four-block group mode, 0: single block |
| in_len | input | 9 | Number of bytes to produce (0..256) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_data | output | 2048 | Data XOR keystream, masked by length |
| out_keep | output | 256 | Per-byte valid mask |
| out_err | output | 1 | Request refused: bad round count |

## Verification
The bench builds the engine with its default parameters: four lanes, a five-bit round count and a nine-bit length. With those values every even count from 2 to 30 can be swept against a bench-side reference permutation, and each odd count and zero can be driven as an error case. Every length from 0 to 256 in group mode and from 0 to 80 in single mode can be covered as well. A counter word near 2^32 exercises the lane counter wrap, and a held-off output exercises the busy and hold behaviour.

// File: rtl/kse_pkg.sv
package kse_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int BLK_BITS  = WORD_W * BLK_WORDS;
  localparam int BLK_BYTES = BLK_BITS / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [BLK_WORDS-1:0] blk_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/kse_qr.sv
module kse_qr
  import kse_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/kse_round.sv
module kse_round
  import kse_pkg::*;
(
  input  blk_t st_i,
  input  logic diag_i,
  output blk_t st_o
);
  localparam int ROWS = 4;
  localparam int COLS = BLK_WORDS / ROWS;

  blk_t rot, mid;

  // bring the diagonals into columns by rotating row r left by r
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < COLS; j++) begin
        rot[r*COLS + j] = st_i[r*COLS + ((j + (diag_i ? r : 0)) % COLS)];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < COLS; g++) begin : g_col
      kse_qr qr_i (
        .a_i(rot[g]), .b_i(rot[COLS+g]), .c_i(rot[2*COLS+g]), .d_i(rot[3*COLS+g]),
        .a_o(mid[g]), .b_o(mid[COLS+g]), .c_o(mid[2*COLS+g]), .d_o(mid[3*COLS+g])
      );
    end
  endgenerate

  // undo the row rotation
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < COLS; j++) begin
        st_o[r*COLS + ((j + (diag_i ? r : 0)) % COLS)] = mid[r*COLS + j];
      end
    end
  end
endmodule

// File: rtl/kse_lane.sv
module kse_lane
  import kse_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic step_i,
  input  logic diag_i,
  input  blk_t seed_i,
  output blk_t ks_o
);
  localparam int CTR_WORD = 12;

  blk_t start, work_q, work_d, rnd;

  always_comb begin
    start = seed_i;
    start[CTR_WORD] = seed_i[CTR_WORD] + word_t'(LANE);
  end

  kse_round round_i (.st_i(work_q), .diag_i(diag_i), .st_o(rnd));

  always_comb begin
    work_d = work_q;
    if (load_i)      work_d = start;
    else if (step_i) work_d = rnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) work_q <= '0;
    else if (load_i || step_i) work_q <= work_d;
  end

  always_comb begin
    for (int i = 0; i < BLK_WORDS; i++) ks_o[i] = work_q[i] + start[i];
  end
endmodule

// File: rtl/kse_block_engine.sv
module kse_block_engine
  import kse_pkg::*;
#(
  parameter int NBLK = 4,
  parameter int RW   = 5,
  parameter int LW   = $clog2(NBLK * BLK_BYTES) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [BLK_BITS-1:0]      in_state,
  input  logic [NBLK*BLK_BITS-1:0] in_data,
  input  logic [RW-1:0]            in_rounds,
  input  logic                     in_multi,
  input  logic [LW-1:0]            in_len,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBLK*BLK_BITS-1:0] out_data,
  output logic [NBLK*BLK_BYTES-1:0] out_keep,
  output logic                     out_err
);
  localparam int TOT_BYTES = NBLK * BLK_BYTES;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} fsm_t;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  fsm_t                     st_q, st_d;
  logic [RW-1:0]            rem_q, rem_d;
  logic                     diag_q, diag_d;
  logic                     err_q, err_d;
  logic                     multi_q;
  logic [LW-1:0]            len_q;
  blk_t                     shadow_q;
  logic [NBLK*BLK_BITS-1:0] data_q;

  logic accept, bad_rounds, load, step, cap_en;

  assign in_ready   = rst_s && (st_q == S_IDLE);
  assign accept     = in_valid && in_ready;
  assign bad_rounds = in_rounds[0] || (in_rounds == '0);
  assign load       = accept && !bad_rounds;
  assign step       = (st_q == S_RUN);
  assign cap_en     = accept;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    diag_d = diag_q;
    err_d  = err_q;
    case (st_q)
      S_IDLE: if (accept) begin
        err_d  = bad_rounds;
        rem_d  = in_rounds;
        diag_d = 1'b0;
        st_d   = bad_rounds ? S_DONE : S_RUN;
      end
      S_RUN: begin
        diag_d = !diag_q;
        if (diag_q) begin
          rem_d = rem_q - RW'(2);
          if (rem_q == RW'(2)) st_d = S_DONE;
        end
      end
      S_DONE: if (out_ready) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      diag_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      diag_q <= diag_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      multi_q  <= 1'b0;
      len_q    <= '0;
      shadow_q <= '0;
      data_q   <= '0;
    end else if (cap_en) begin
      multi_q  <= in_multi;
      len_q    <= in_len;
      shadow_q <= blk_t'(in_state);
      data_q   <= in_data;
    end
  end

  // lanes: lane 0 always runs, the others only in group mode
  blk_t                     seed;
  blk_t                     ks_w [NBLK];
  logic [NBLK*BLK_BITS-1:0] ks_flat;

  assign seed = load ? blk_t'(in_state) : shadow_q;

  genvar l;
  generate
    for (l = 0; l < NBLK; l++) begin : g_lane
      logic lane_en;
      if (l == 0) begin : g_first
        assign lane_en = 1'b1;
      end else begin : g_rest
        assign lane_en = load ? in_multi : multi_q;
      end
      kse_lane #(.LANE(l)) lane_i (
        .clk(clk), .rst_n(rst_s),
        .load_i(load && lane_en), .step_i(step && lane_en), .diag_i(diag_q),
        .seed_i(seed), .ks_o(ks_w[l])
      );
      assign ks_flat[l*BLK_BITS +: BLK_BITS] = ks_w[l];
    end
  endgenerate

  // byte mask and output combination
  always_comb begin
    for (int b = 0; b < TOT_BYTES; b++) begin
      out_keep[b] = !err_q && (LW'(b) < len_q) && (multi_q || (b < BLK_BYTES));
      out_data[8*b +: 8] = out_keep[b] ? (data_q[8*b +: 8] ^ ks_flat[8*b +: 8]) : 8'h00;
    end
  end

  assign out_valid = (st_q == S_DONE);
  assign out_err   = out_valid && err_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> !in_ready);
  assert_errmask_R5: assert property (@(posedge clk) disable iff (!rst_s)
    out_err |-> (out_keep == '0));
  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !multi_q |-> (out_keep[TOT_BYTES-1:BLK_BYTES] == '0));
  assert_lenmask_R7: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> ($countones(out_keep) <= int'(len_q)));
  assert_evenrem_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_RUN) |-> (rem_q[0] == 1'b0 && rem_q != '0));
endmodule

// File: tb/kse_block_engine_tb_top.sv
module kse_block_engine_tb_top;
  localparam int NB = 4;
  localparam int DW = NB * 512;
  localparam int KB = NB * 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [511:0]  in_state = '0;
  logic [DW-1:0] in_data = '0;
  logic [4:0]    in_rounds = '0;
  logic          in_multi = 1'b0;
  logic [8:0]    in_len = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [KB-1:0] out_keep;
  logic          out_err;

  always #5 clk = ~clk;

  kse_block_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_state(in_state), .in_data(in_data), .in_rounds(in_rounds),
    .in_multi(in_multi), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
    .out_err(out_err)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  logic [DW-1:0] got_data, exp_data;
  logic [KB-1:0] got_keep, exp_keep;
  logic          got_err;
  int            got_lat;
  bit            hold_ok;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // straightforward reference: explicit column and diagonal index sets
  function automatic logic [511:0] ref_ks(input logic [511:0] s, input int rounds);
    logic [31:0] x [16];
    int q [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                     '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    logic [511:0] r;
    for (int i = 0; i < 16; i++) x[i] = s[32*i +: 32];
    for (int it = 0; it < rounds / 2; it++) begin
      for (int k = 0; k < 8; k++) begin
        int a = q[k][0]; int b = q[k][1]; int c = q[k][2]; int d = q[k][3];
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 12);
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 7);
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[32*i +: 32];
    return r;
  endfunction

  task automatic expect_out(input logic [511:0] s, input logic [DW-1:0] d,
                            input int rounds, input bit m, input int len);
    logic [DW-1:0] ks;
    for (int k = 0; k < NB; k++) begin
      logic [511:0] sk = s;
      sk[12*32 +: 32] = s[12*32 +: 32] + 32'(k);
      ks[512*k +: 512] = ref_ks(sk, rounds);
    end
    for (int b = 0; b < KB; b++) begin
      exp_keep[b] = (b < len) && (m || b < 64);
      exp_data[8*b +: 8] = exp_keep[b] ? (d[8*b +: 8] ^ ks[8*b +: 8]) : 8'h00;
    end
  endtask

  task automatic txn(input logic [511:0] s, input logic [DW-1:0] d, input int rounds,
                     input bit m, input int len, input int hold);
    @(negedge clk);
    in_valid = 1'b1; in_state = s; in_data = d;
    in_rounds = 5'(rounds); in_multi = m; in_len = 9'(len);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    got_lat = 1;
    while (!out_valid && got_lat < 100) begin
      @(negedge clk);
      got_lat++;
    end
    got_data = out_data; got_keep = out_keep; got_err = out_err;
    hold_ok = 1'b1;
    if (hold > 0) begin
      in_valid = 1'b1; in_state = ~s; in_data = ~d; in_rounds = 5'd2; in_multi = 1'b1; in_len = 9'd256;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if (!out_valid || in_ready || out_data != got_data || out_keep != got_keep) hold_ok = 1'b0;
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [511:0] mkstate(input int seed);
    logic [511:0] r;
    logic [31:0]  v = 32'(seed) * 32'h9e3779b9 + 32'h1234567;
    for (int i = 0; i < 16; i++) begin
      v = v * 32'd1664525 + 32'd1013904223;
      r[32*i +: 32] = v ^ (v >> 13);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] mkdata(input int seed);
    logic [DW-1:0] r;
    for (int k = 0; k < 4; k++) r[512*k +: 512] = mkstate(seed * 7 + k + 1);
    return r;
  endfunction

  initial begin
    logic [511:0] s;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state",
        $sformatf("rdy=%0b vld=%0b", in_ready, out_valid), "rdy=1 vld=0");

    // R3: standard test state
    s = '0;
    s[0*32 +: 32] = 32'h61707865; s[1*32 +: 32] = 32'h3320646e;
    s[2*32 +: 32] = 32'h79622d32; s[3*32 +: 32] = 32'h6b206574;
    for (int i = 0; i < 8; i++)
      s[(4+i)*32 +: 32] = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
    s[12*32 +: 32] = 32'd1; s[13*32 +: 32] = 32'h09000000; s[14*32 +: 32] = 32'h4a000000;
    txn(s, '0, 20, 1'b0, 64, 0);
    chk(got_data[31:0] == 32'he4e7f110, "R3 test-vector word 0",
        $sformatf("%h", got_data[31:0]), "e4e7f110");
    expect_out(s, '0, 20, 1'b0, 64);
    chk(got_data == exp_data, "R3 test-vector block", $sformatf("%h", got_data[511:0]),
        $sformatf("%h", exp_data[511:0]));

    // R2 / R4 / R9: every even round count, single mode
    for (int r = 2; r <= 30; r += 2) begin
      s = mkstate(r); d = mkdata(r);
      txn(s, d, r, 1'b0, 64, 0);
      expect_out(s, d, r, 1'b0, 64);
      chk(got_data == exp_data && !got_err, $sformatf("R2 rounds=%0d", r),
          $sformatf("%h", got_data[511:0]), $sformatf("%h", exp_data[511:0]));
      chk(got_lat == r + 1, $sformatf("R4 latency rounds=%0d", r),
          $sformatf("%0d", got_lat), $sformatf("%0d", r + 1));
      chk(got_keep == exp_keep && got_data[DW-1:512] == '0, $sformatf("R9 single keep rounds=%0d", r),
          $sformatf("%h", got_keep), $sformatf("%h", exp_keep));
    end

    // R5: odd and zero round counts
    for (int r = 0; r < 32; r++) begin
      if (r % 2 == 1 || r == 0) begin
        txn(mkstate(r + 40), mkdata(r), r, 1'b1, 256, 0);
        chk(got_err && got_keep == '0 && got_data == '0 && got_lat == 1,
            $sformatf("R5 bad rounds=%0d", r),
            $sformatf("err=%0b keep=%0d lat=%0d", got_err, $countones(got_keep), got_lat),
            "err=1 keep=0 lat=1");
      end
    end

    // R6: group mode, including counter wrap
    for (int c = 0; c < 4; c++) begin
      s = mkstate(100 + c); d = mkdata(100 + c);
      s[12*32 +: 32] = 32'hffffffff - 32'(c);
      txn(s, d, 8, 1'b1, 256, 0);
      expect_out(s, d, 8, 1'b1, 256);
      chk(got_data == exp_data && got_keep == exp_keep, $sformatf("R6 lanes ctr=%h", s[12*32 +: 32]),
          $sformatf("%h", got_data), $sformatf("%h", exp_data));
    end

    // R7: length sweep in group mode
    for (int len = 0; len <= 256; len++) begin
      s = mkstate(300 + len); d = mkdata(len);
      txn(s, d, 2, 1'b1, len, 0);
      expect_out(s, d, 2, 1'b1, len);
      chk(got_data == exp_data && got_keep == exp_keep, $sformatf("R7 len=%0d", len),
          $sformatf("%h", got_keep), $sformatf("%h", exp_keep));
    end

    // R9: length sweep in single mode
    for (int len = 0; len <= 80; len++) begin
      s = mkstate(700 + len); d = mkdata(len + 5);
      txn(s, d, 4, 1'b0, len, 0);
      expect_out(s, d, 4, 1'b0, len);
      chk(got_data == exp_data && got_keep == exp_keep, $sformatf("R9 single len=%0d", len),
          $sformatf("%h", got_keep), $sformatf("%h", exp_keep));
    end

    // R8: back-pressure, busy input ignored
    s = mkstate(999); d = mkdata(999);
    txn(s, d, 12, 1'b1, 200, 6);
    expect_out(s, d, 12, 1'b1, 200);
    chk(hold_ok, "R8 hold under back-pressure", $sformatf("%0b", hold_ok), "1");
    chk(got_data == exp_data, "R8 result of first request", $sformatf("%h", got_data[511:0]),
        $sformatf("%h", exp_data[511:0]));
    @(negedge clk);
    chk(in_ready && !out_valid, "R8 idle after handshake, offered request dropped",
        $sformatf("rdy=%0b vld=%0b", in_ready, out_valid), "rdy=1 vld=0");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule